// File: doc/BRIEF.md
# Permission Indirection Lookup Decoder

This block holds a programmable 64-bit indirection table of sixteen 4-bit permission codes. Each access-check request carries a 4-bit index that picks one slot of the table. The code found there is decoded into separate permission flags: read, write, execute, shadow-stack read and shadow-stack write. A further flag reports whether an overlay must still be applied. Reserved codes collapse to no access.

Software loads the whole table in one cycle through a write port with an enable and 64-bit data. A global enable input switches the indirection scheme off. While the scheme is off, the table is ignored, every flag is low and a bypass output tells the surrounding logic to use its legacy permission path. Results are registered and appear one cycle after the request, together with a response-valid strobe.

Top module: `perm_indir_lookup`

## Requirements
- R1: Index m selects the code held in table bits [4m+3:4m], for m from 0 to 15.
- R2: With the scheme enabled, the overlay flag is set and codes 0000, 0001, 0010 and 0011 give no access, read, execute and read+execute.
- R3: With the scheme enabled, code 0101 gives read+write, and codes 0110 and 0111 both give read+write+execute, each with the overlay flag set.
- R4: Reserved code 0100 gives no read, write, execute or shadow-stack flag, with the overlay flag set.
- R5: Codes 1000, 1010, 1100 and 1110 give read, read+execute, read+write and read+write+execute, each with the overlay flag clear.
- R6: Code 1001 gives read, shadow-stack read and shadow-stack write, with no write or execute and the overlay flag clear.
- R7: Reserved codes 1011, 1101 and 1111 give no permission flag at all and the overlay flag clear.
- R8: When the enable input is low at a request, the response has every permission flag and the overlay flag low and bypass high, whatever the table holds; with the enable high, bypass is low.
- R9: Response valid is high exactly one cycle after a cycle with a request; in a cycle without a response, every flag and bypass are low.
- R10: A table write in the same cycle as a request does not affect that request; the next request sees the new contents.
- R11: Reset clears the table to all zeros, so each slot then gives no access with the overlay flag set, and response valid is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_wdata | input | 64 | New table contents |
| indir_en | input | 1 | Indirection scheme enable |
| req_valid | input | 1 | Lookup request strobe |
| req_idx | input | 4 | Slot index of the request |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_ss_rd | output | 1 | Shadow-stack read permitted |
| rsp_ss_wr | output | 1 | Shadow-stack write permitted |
| rsp_overlay | output | 1 | Overlay still to be applied |
| rsp_bypass | output | 1 | Scheme disabled, use the legacy path |

## Verification
The bench loads a table where slot m holds code m, so every one of the sixteen codes is decoded through its own slot; a decoder that let a reserved code grant access, or lost the overlay bit for 0100, would show a flag mismatch there. A write issued in the same cycle as a lookup catches a design that forwards the new data early, and disabled lookups over a table full of permissive codes catch one that leaks flags while bypassing. Random tables and indices then expose slice errors that would fetch a neighbouring slot.

// File: rtl/perm_indir_pkg.sv
package perm_indir_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic ss_rd;
    logic ss_wr;
    logic overlay;
  } perm_flags_t;
endpackage

// File: rtl/perm_slot_store.sv
module perm_slot_store #(
  parameter int SLOTS  = 16,
  parameter int CODE_W = 4,
  localparam int TBL_W = SLOTS * CODE_W,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [TBL_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] code
);
  logic [TBL_W-1:0]  tbl_q;
  logic [CODE_W-1:0] slot [SLOTS];

  always_ff @(posedge clk) begin
    if (rst)     tbl_q <= '0;
    else if (we) tbl_q <= wdata;
  end

  for (genvar m = 0; m < SLOTS; m++) begin : g_slot
    assign slot[m] = tbl_q[m*CODE_W +: CODE_W];
  end

  assign code = slot[idx];

  // R11: the cycle after reset the table is empty
  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tbl_q == '0));
  // R10: a written value is held until the next write
  assert_table_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(we) && !$past(rst) |-> $stable(tbl_q));
endmodule

// File: rtl/perm_code_decode.sv
module perm_code_decode
  import perm_indir_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output perm_flags_t       flags
);
  always_comb begin
    flags = '0;
    flags.overlay = ~code[3];
    unique case (code)
      4'b0001: flags.rd = 1'b1;
      4'b0010: flags.ex = 1'b1;
      4'b0011: begin flags.rd = 1'b1; flags.ex = 1'b1; end
      4'b0101: begin flags.rd = 1'b1; flags.wr = 1'b1; end
      4'b0110,
      4'b0111: begin flags.rd = 1'b1; flags.wr = 1'b1; flags.ex = 1'b1; end
      4'b1000: flags.rd = 1'b1;
      4'b1001: begin flags.rd = 1'b1; flags.ss_rd = 1'b1; flags.ss_wr = 1'b1; end
      4'b1010: begin flags.rd = 1'b1; flags.ex = 1'b1; end
      4'b1100: begin flags.rd = 1'b1; flags.wr = 1'b1; end
      4'b1110: begin flags.rd = 1'b1; flags.wr = 1'b1; flags.ex = 1'b1; end
      default: ; // 0000 and the reserved codes: no access
    endcase
  end
endmodule

// File: rtl/perm_indir_lookup.sv
module perm_indir_lookup
  import perm_indir_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int TBL_W = SLOTS * CODE_W,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [TBL_W-1:0] tbl_wdata,
  input  logic             indir_en,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  output logic             rsp_valid,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  output logic             rsp_ss_rd,
  output logic             rsp_ss_wr,
  output logic             rsp_overlay,
  output logic             rsp_bypass
);
  logic [CODE_W-1:0] sel_code;
  perm_flags_t       dec_flags;
  perm_flags_t       flags_q;
  logic              valid_q, bypass_q;

  perm_slot_store #(.SLOTS(SLOTS), .CODE_W(CODE_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (tbl_we),
    .wdata (tbl_wdata),
    .idx   (req_idx),
    .code  (sel_code)
  );

  perm_code_decode u_decode (
    .code  (sel_code),
    .flags (dec_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      bypass_q <= 1'b0;
      flags_q  <= '0;
    end else begin
      valid_q  <= req_valid;
      bypass_q <= req_valid & ~indir_en;
      flags_q  <= (req_valid && indir_en) ? dec_flags : '0;
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_bypass  = bypass_q;
  assign rsp_rd      = flags_q.rd;
  assign rsp_wr      = flags_q.wr;
  assign rsp_ex      = flags_q.ex;
  assign rsp_ss_rd   = flags_q.ss_rd;
  assign rsp_ss_wr   = flags_q.ss_wr;
  assign rsp_overlay = flags_q.overlay;

  // R9: response strobe follows a request by one cycle
  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_rd | rsp_wr | rsp_ex | rsp_ss_rd | rsp_ss_wr | rsp_overlay | rsp_bypass));
  // R8: a disabled request yields bypass and no flags
  assert_bypass_clean_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && !indir_en |=> rsp_bypass && !(rsp_rd | rsp_wr | rsp_ex | rsp_ss_rd | rsp_ss_wr | rsp_overlay));
  // R6: shadow-stack write only comes with the plain read form of code 1001
  assert_ss_form_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_ss_wr |-> rsp_ss_rd && rsp_rd && !rsp_wr && !rsp_ex && !rsp_overlay);
  // R3 / R5: every write grant also grants read
  assert_write_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_wr |-> rsp_rd);
  // R11: no response straight after reset
  assert_no_rsp_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);
endmodule

// File: tb/test_perm_indir_lookup.sv
module test_perm_indir_lookup;
  logic        clk = 1'b0;
  logic        rst;
  logic        tbl_we;
  logic [63:0] tbl_wdata;
  logic        indir_en;
  logic        req_valid;
  logic [3:0]  req_idx;
  logic rsp_valid, rsp_rd, rsp_wr, rsp_ex, rsp_ss_rd, rsp_ss_wr, rsp_overlay, rsp_bypass;

  int checks = 0;
  int errors = 0;
  logic [63:0] model_tbl;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perm_indir_lookup i_perm_indir_lookup (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
    .indir_en(indir_en), .req_valid(req_valid), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .rsp_ss_rd(rsp_ss_rd), .rsp_ss_wr(rsp_ss_wr), .rsp_overlay(rsp_overlay),
    .rsp_bypass(rsp_bypass)
  );

  // {valid, rd, wr, ex, ss_rd, ss_wr, overlay, bypass}
  function automatic logic [7:0] expect_code(input logic [3:0] c);
    logic [5:0] f;
    case (c)
      4'd0:  f = 6'b000001;
      4'd1:  f = 6'b100001;
      4'd2:  f = 6'b001001;
      4'd3:  f = 6'b101001;
      4'd4:  f = 6'b000001;
      4'd5:  f = 6'b110001;
      4'd6:  f = 6'b111001;
      4'd7:  f = 6'b111001;
      4'd8:  f = 6'b100000;
      4'd9:  f = 6'b100110;
      4'd10: f = 6'b101000;
      4'd12: f = 6'b110000;
      4'd14: f = 6'b111000;
      default: f = 6'b000000;
    endcase
    return {1'b1, f, 1'b0};
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd3: return "R2";
      4'd5, 4'd6, 4'd7:       return "R3";
      4'd4:                   return "R4";
      4'd8, 4'd10, 4'd12, 4'd14: return "R5";
      4'd9:                   return "R6";
      default:                return "R7";
    endcase
  endfunction

  function automatic logic [7:0] observed();
    return {rsp_valid, rsp_rd, rsp_wr, rsp_ex, rsp_ss_rd, rsp_ss_wr, rsp_overlay, rsp_bypass};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, observed(), exp);
    end
  endtask

  // drive at negedge, sample one unit after the capturing posedge
  task automatic cycle(input logic we, input logic [63:0] wd, input logic v,
                       input logic en, input logic [3:0] idx);
    @(negedge clk);
    tbl_we = we; tbl_wdata = wd; req_valid = v; indir_en = en; req_idx = idx;
    @(posedge clk);
    #1;
    tbl_we = 1'b0; req_valid = 1'b0;
  endtask

  task automatic lookup(input logic en, input logic [3:0] idx, input string req);
    logic [3:0] c;
    c = model_tbl[idx*4 +: 4];
    cycle(1'b0, '0, 1'b1, en, idx);
    check(req, en ? expect_code(c) : 8'b1000_0001);
  endtask

  task automatic load(input logic [63:0] v);
    cycle(1'b1, v, 1'b0, 1'b1, 4'd0);
    model_tbl = v;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4127));
    rst = 1'b1; tbl_we = 1'b0; tbl_wdata = '0; indir_en = 1'b1;
    req_valid = 1'b0; req_idx = '0; model_tbl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R11", 8'b0);
    // R11: empty table gives no access with overlay in each slot
    for (int m = 0; m < 16; m++) lookup(1'b1, 4'(m), "R11");
    // R1..R7: slot m holds code m
    load(64'hFEDC_BA98_7654_3210);
    for (int m = 0; m < 16; m++) lookup(1'b1, 4'(m), tag_of(4'(m)));
    // R1: reversed table, slot m holds 15-m
    load(64'h0123_4567_89AB_CDEF);
    for (int m = 0; m < 16; m++) lookup(1'b1, 4'(m), "R1");
    // R8: disabled with permissive codes everywhere
    load(64'h6666_EEEE_9999_7777);
    for (int m = 0; m < 16; m += 3) lookup(1'b0, 4'(m), "R8");
    // R9: idle cycle after a response
    cycle(1'b0, '0, 1'b0, 1'b1, 4'd0);
    check("R9", 8'b0);
    // R10: write together with lookup sees old code, next sees new
    load(64'h0000_0000_0000_0006);
    cycle(1'b1, 64'h0000_0000_0000_000B, 1'b1, 1'b1, 4'd0);
    check("R10", expect_code(4'd6));
    model_tbl = 64'h0000_0000_0000_000B;
    lookup(1'b1, 4'd0, "R10");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) load({$urandom, $urandom});
      else if (r == 1) begin
        cycle(1'b0, '0, 1'b0, 1'b1, 4'd0);
        check("R9", 8'b0);
      end else lookup((r != 2), 4'($urandom_range(0, 15)), (r == 2) ? "R8" : "R1");
    end
    // R11: reset after a load clears the table
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_tbl = '0;
    @(posedge clk); #1;
    check("R11", 8'b0);
    lookup(1'b1, 4'd7, "R11");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule